// File: doc/BRIEF.md
# Three-Channel Microsecond Periodic Timer

This peripheral provides three independent periodic event sources for a system that needs interrupts at microsecond-scale intervals. One shared divider turns the system clock into a tick that is nominally one microsecond long. Software programs that divider once for the clock frequency, and the tick then paces all three channels. For example, a 25 ns clock with a divider value of 39 gives a 1 µs tick.

Each channel has its own configuration word. The word holds an enable flag and a reload value N. While the channel is enabled it emits a single-clock pulse once every N+1 ticks, and the pulses continue until software disables the channel. Every pulse sets a sticky status bit. A mask register gates the status bits onto the interrupt lines, and software removes a status bit by writing a one to it through a separate clear address.

Software reaches the block through a simple register port. Writes take effect on the clock edge that samples them. Reads return data combinationally for the address presented.

Top module: `usec_timer_top`

## Requirements
- R1: While rst_n is low, and after it is released, the divider value, the three configuration words, the status bits and the mask all read zero. Both the pulse outputs and the interrupt outputs are low.
- R2: With divider value P and reload value N, an enabled channel's pulse rises every (N+1)*(P+1) clock cycles, and the interval stays the same from one pulse to the next. Writing the divider restarts the division from zero.
- R3: When the period is longer than one clock, each pulse is high for exactly one clock cycle.
- R4: The register map is:
  - address 0: divider value in bits [15:0];
  - addresses 1, 2 and 3: the configuration words of channels 0, 1 and 2, with bit 16 as the enable and bits [15:0] as N;
  - address 4: the status bits in [2:0], read only;
  - address 5: the clear register, [2:0], write-one-to-clear;
  - address 6: the mask in [2:0].

  The divider, configuration and mask registers read back what was last written to them.
- R5: A channel whose enable bit is 0 produces no pulses. Its N field is kept and reads back unchanged.
- R6: A write to a channel's configuration word restarts that channel's count from zero. With P = 0, the first pulse is high in the (N+1)th clock cycle after the write edge.
- R7: A status bit that has been set stays set, including after its channel is disabled, until a one is written to the matching bit of the clear register. Zero bits in a clear write have no effect.
- R8: Interrupt line i is high exactly when status bit i and mask bit i are both 1.
- R9: If a channel pulse and a clear write for the same status bit occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 17 | Register write data |
| reg_rdata | output | 17 | Read data for reg_addr, combinational |
| tmr_pulse | output | 3 | Raw one-clock pulse per channel |
| irq | output | 3 | Masked sticky interrupt per channel |

## Verification
The bench builds the block with its package defaults: three channels, a 16-bit reload field and a 16-bit divider. It drives small divider values (0, 1, 3, 7 and 39), so every programmed period is between 2 and 120 clocks. At those lengths the exact interval between pulses, the pulse width and the restart latency can each be counted cycle by cycle. With a divider of zero the ticks have no phase uncertainty, which lets the bench land a clear write on exactly the same cycle as a channel pulse.

// File: rtl/usec_tmr_pkg.sv
package usec_tmr_pkg;
  localparam int NUM_CH  = 3;
  localparam int CNT_W   = 16;
  localparam int PRESC_W = 16;
  localparam int ADDR_W  = 3;
  localparam int REG_W   = CNT_W + 1;

  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG0  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(1 + NUM_CH);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(2 + NUM_CH);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(3 + NUM_CH);

  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] reload;
  } tmr_cfg_t;
endpackage

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
  import usec_tmr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] div_i,
  input  logic               restart_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || tick_o) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: the divider count never passes the programmed value
  p_div_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_i);
endmodule

// File: rtl/usec_reload_tmr.sv
module usec_reload_tmr
  import usec_tmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  tmr_cfg_t cfg_i,
  input  logic     load_i,
  output logic     pulse_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_d;
  logic             hit;

  assign hit = (cnt_q == cfg_i.reload);

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (load_i) begin
      cnt_d = '0;
    end else if (cfg_i.en && tick_i) begin
      pulse_d = hit;
      cnt_d   = hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_o <= pulse_d;
    end
  end

  // R6: after any reload the count stays within the programmed window
  p_cnt_within_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cfg_i.reload);
  // R5: a pulse only follows a cycle in which the channel was enabled
  p_pulse_needs_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(cfg_i.en));
endmodule

// File: rtl/usec_irq_latch.sv
module usec_irq_latch
  import usec_tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic              mask_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] status_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] status_d, mask_d, clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_comb begin
    status_d = (status_o & ~clr_bits) | evt_i;
    mask_d   = mask_o;
    if (mask_we_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      mask_o   <= '0;
    end else begin
      status_o <= status_d;
      mask_o   <= mask_d;
    end
  end

  assign irq_o = status_o & mask_o;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R7: a set bit survives unless its own clear bit is written
    p_status_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[g] && !(clr_we_i && wdata_i[g])) |=> status_o[g]);
    // R9: an event always leaves its bit set, even against a clear
    p_event_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> status_o[g]);
  end
endmodule

// File: rtl/usec_timer_top.sv
module usec_timer_top
  import usec_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] tmr_pulse,
  output logic [NUM_CH-1:0] irq
);
  logic [1:0]         rst_sync_q;
  logic               rst_sn;
  logic [PRESC_W-1:0] presc_q, presc_d;
  tmr_cfg_t           cfg_q [NUM_CH];
  tmr_cfg_t           cfg_d [NUM_CH];
  logic [NUM_CH-1:0]  cfg_we;
  logic               presc_we, clr_we, mask_we, tick;
  logic [NUM_CH-1:0]  status, mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign presc_we = reg_we && (reg_addr == A_PRESC);
  assign clr_we   = reg_we && (reg_addr == A_CLR);
  assign mask_we  = reg_we && (reg_addr == A_MASK);

  always_comb begin
    presc_d = presc_q;
    if (presc_we) presc_d = reg_wdata[PRESC_W-1:0];
    for (int i = 0; i < NUM_CH; i++) begin
      cfg_we[i] = reg_we && (reg_addr == ADDR_W'(int'(A_CFG0) + i));
      cfg_d[i]  = cfg_we[i] ? tmr_cfg_t'(reg_wdata) : cfg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      presc_q <= '0;
      for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= '0;
    end else begin
      presc_q <= presc_d;
      for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= cfg_d[i];
    end
  end

  usec_tick_gen u_tick (
    .clk_i     (clk),
    .rst_ni    (rst_sn),
    .div_i     (presc_q),
    .restart_i (presc_we),
    .tick_o    (tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    usec_reload_tmr u_tmr (
      .clk_i   (clk),
      .rst_ni  (rst_sn),
      .tick_i  (tick),
      .cfg_i   (cfg_q[g]),
      .load_i  (cfg_we[g]),
      .pulse_o (tmr_pulse[g])
    );
  end

  usec_irq_latch u_irq (
    .clk_i     (clk),
    .rst_ni    (rst_sn),
    .evt_i     (tmr_pulse),
    .clr_we_i  (clr_we),
    .mask_we_i (mask_we),
    .wdata_i   (reg_wdata[NUM_CH-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_PRESC) reg_rdata = REG_W'(presc_q);
    if (reg_addr == A_STAT)  reg_rdata = REG_W'(status);
    if (reg_addr == A_MASK)  reg_rdata = REG_W'(mask);
    for (int i = 0; i < NUM_CH; i++)
      if (reg_addr == ADDR_W'(int'(A_CFG0) + i)) reg_rdata = cfg_q[i];
  end
endmodule

// File: tb/usec_timer_top_tb_top.sv
module usec_timer_top_tb_top;
  import usec_tmr_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic [NUM_CH-1:0] tmr_pulse, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usec_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_pulse(tmr_pulse), .irq(irq)
  );

  // {channel[8], divider[16], reload[16], expected period in clocks[16]}
  localparam logic [55:0] VEC [6] = '{
    {8'd0, 16'd0,  16'd1, 16'd2},
    {8'd1, 16'd0,  16'd5, 16'd6},
    {8'd2, 16'd3,  16'd4, 16'd20},
    {8'd0, 16'd39, 16'd2, 16'd120},
    {8'd1, 16'd1,  16'd9, 16'd20},
    {8'd2, 16'd7,  16'd0, 16'd8}
  };

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [REG_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic measure(int ch, output int period, output int width);
    bit prev, cnt_hi;
    prev = tmr_pulse[ch];
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (tmr_pulse[ch] && !prev) break;
      prev = tmr_pulse[ch];
    end
    prev = 1'b1; cnt_hi = 1'b1; width = 1; period = 0;
    for (int k = 1; k < 5000; k++) begin
      @(negedge clk);
      if (tmr_pulse[ch] && !prev) begin period = k; break; end
      if (tmr_pulse[ch] && cnt_hi) width++;
      else if (!tmr_pulse[ch]) cnt_hi = 1'b0;
      prev = tmr_pulse[ch];
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, per, wid, k, hits;
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rd(ADDR_W'(a), v); chk("R1 reg reset", v, 0);
    end
    chk("R1 pulse reset", int'(tmr_pulse), 0);
    chk("R1 irq reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_STAT, v); chk("R1 status after release", v, 0);

    // Table-driven period, width, disable and readback tests
    for (int i = 0; i < 6; i++) begin
      int ch, p, n, ex;
      ch = int'(VEC[i][55:48]); p = int'(VEC[i][47:32]);
      n = int'(VEC[i][31:16]);  ex = int'(VEC[i][15:0]);
      wr(A_PRESC, REG_W'(p));
      rd(A_PRESC, v); chk("R4 divider readback", v, p);
      wr(ADDR_W'(1 + ch), {1'b1, 16'(n)});
      rd(ADDR_W'(1 + ch), v); chk("R4 config readback", v, (1 << 16) | n);
      measure(ch, per, wid);
      chk("R2 period", per, ex);
      measure(ch, per, wid);
      chk("R2 period repeats", per, ex);
      chk("R3 pulse width", wid, 1);
      wr(ADDR_W'(1 + ch), {1'b0, 16'(n)});
      hits = 0;
      for (int c = 0; c < 3 * ex; c++) begin
        @(negedge clk);
        if (tmr_pulse[ch]) hits++;
      end
      chk("R5 no pulse when disabled", hits, 0);
      rd(ADDR_W'(1 + ch), v); chk("R5 reload kept", v, n);
    end

    // R7 / R8: sticky status, mask gating, W1C
    rd(A_STAT, v); chk("R7 status sticky after disable", v, 7);
    chk("R8 irq masked off", int'(irq), 0);
    wr(A_MASK, 17'h5);
    rd(A_MASK, v); chk("R4 mask readback", v, 5);
    chk("R8 irq gated", int'(irq), 5);
    wr(A_CLR, 17'h1);
    rd(A_STAT, v); chk("R7 w1c one bit", v, 6);
    chk("R8 irq after clear", int'(irq), 4);
    wr(A_CLR, 17'h0);
    rd(A_STAT, v); chk("R7 zero clear no effect", v, 6);
    wr(A_CLR, 17'h6);
    rd(A_STAT, v); chk("R7 all cleared", v, 0);
    chk("R8 irq low when clear", int'(irq), 0);

    // R6: config rewrite restarts period (P = 0)
    wr(A_PRESC, 17'd0);
    wr(A_CFG0, {1'b1, 16'd9});
    repeat (4) @(negedge clk);
    wr(A_CFG0, {1'b1, 16'd4});
    k = 0;
    for (int c = 1; c < 40; c++) begin
      @(negedge clk);
      if (tmr_pulse[0]) begin k = c; break; end
    end
    chk("R6 restart latency", k, 5);
    wr(A_CFG0, {1'b0, 16'd4});
    wr(A_CLR, 17'h7);

    // R9: pulse and clear in same cycle
    wr(ADDR_W'(2), {1'b1, 16'd20});
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (tmr_pulse[1]) break;
    end
    reg_we = 1'b1; reg_addr = A_CLR; reg_wdata = 17'h2;
    @(negedge clk);
    reg_we = 1'b0;
    rd(A_STAT, v); chk("R9 event beats clear", v & 2, 2);
    wr(ADDR_W'(2), {1'b0, 16'd20});
    wr(A_CLR, 17'h2);
    rd(A_STAT, v); chk("R7 clear after collision", v, 0);

    // R1: reset in mid-run
    wr(A_MASK, 17'h7);
    wr(ADDR_W'(3), {1'b1, 16'd1});
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 pulse cleared by reset", int'(tmr_pulse), 0);
    chk("R1 irq cleared by reset", int'(irq), 0);
    rd(ADDR_W'(3), v); chk("R1 config cleared", v, 0);
    rd(A_MASK, v); chk("R1 mask cleared", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule